// File: doc/BRIEF.md
# Serial-Loaded Bank Control Registers

This block is the write side of a cartridge bank-switching controller. The CPU has no parallel path into the controller's registers. Instead it feeds them one bit per bus write. Each accepted write shifts data bit 0 into a five-bit staging register. On the fifth accepted write, the assembled value goes to one of four registers: a control register, two character-bank registers and a program-bank register. Address bits 14:13 choose which one.

A write with data bit 7 set restarts the sequence. It empties the staging register and forces the two program-mode bits of the control register high. Read-modify-write instructions issue a dummy write one cycle before the real one. A timing filter drops any ordinary write that lands fewer than two cycles after the previous write, so that the dummy write does not also shift in a bit.

The outputs are the committed register fields, all registered. The block also reports which character-bank register was loaded last. Address translation is left to the logic that consumes these fields.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each accepted write with data bit 7 clear shifts the staging register right by one and places data bit 0 at bit 4. The first accepted bit therefore ends up as bit 0 of the committed value, and data bits 6:1 have no effect.
- R2: The fifth accepted bit commits the five-bit value to the register selected by `wr_page[1:0]`: 0 selects control, 1 selects CHR bank low, 2 selects CHR bank high and 3 selects PRG. The staging state then clears, so the next commit needs five new bits. No register changes without a commit or a restart.
- R3: A write with data bit 7 set is always accepted. It discards its data and clears the staging state. It sets control bits 2 and 3 and leaves control bits 4, 1 and 0 unchanged.
- R4: Control register fields: bits 1:0 drive `mirror_mode` (0 single-screen A, 1 single-screen B, 2 vertical, 3 horizontal), bit 2 drives `prg_slot_sel`, bit 3 drives `prg_mode` and bit 4 drives `chr_mode`.
- R5: Each CHR bank register keeps all five bits. The PRG register puts bits 3:0 on `prg_bank` and bit 4 on `wram_off`.
- R6: A write with bit 7 clear is dropped if its `cycle_now` is less than 2 past the previous write. The comparison uses the last write whether that write was accepted or not, so a chain of writes on adjacent cycles passes only its first member. The first write after reset is always accepted.
- R7: After synchronous reset, the control register is 5'b01100, both CHR banks, `prg_bank` and `wram_off` are 0, and the staging state is empty.
- R8: `last_chr_hi` is 0 after reset. It becomes 1 on a commit to CHR bank high and returns to 0 on a commit to CHR bank low.
- R9: A strobe with `wr_page[2]` = 0 is outside the register window. It neither shifts a bit nor updates the last-write time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe, one cycle per bus write |
| wr_page | input | 3 | Address bits 15:13 of the write |
| wr_data | input | 8 | Write data; bit 7 restarts, bit 0 is the serial bit |
| cycle_now | input | CW | Free-running cycle count used by the timing filter |
| mirror_mode | output | 2 | Nametable arrangement from control bits 1:0 |
| prg_slot_sel | output | 1 | Control bit 2 |
| prg_mode | output | 1 | Control bit 3 |
| chr_mode | output | 1 | Control bit 4 |
| chr_bank_lo | output | 5 | First CHR bank register |
| chr_bank_hi | output | 5 | Second CHR bank register |
| prg_bank | output | 4 | PRG bank number |
| wram_off | output | 1 | Work-RAM disable flag |
| last_chr_hi | output | 1 | 1 if the most recent CHR commit went to the second register |

## Verification
Corrupt staging state does not show at the ports right away. It appears only at the next commit, up to five accepted writes later, as a wrong value in the selected register or a commit that arrives one bit early or late. The bench checks every output field after every five-write load, so a miscount or a bit-order error shows within one load. A filter that admits a dummy write, or fails to refresh its timestamp on a dropped write, shifts the whole bit sequence. That produces a wrong committed value at the end of the same load. A restart that clears the wrong state shows at the following commit, and a restart that touches the wrong control bits shows on the cycle after the restart.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int SR_W = 5;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CHR_LO = 2'd1,
    SEL_CHR_HI = 2'd2,
    SEL_PRG    = 2'd3
  } reg_sel_e;

  // right shift, new bit enters at the top
  function automatic logic [SR_W-1:0] shift_step(input logic [SR_W-1:0] sr, input logic b);
    return {b, sr[SR_W-1:1]};
  endfunction

  // spacing test for the dummy-write filter
  function automatic logic gap_ok(input logic [31:0] now_c, input logic [31:0] last_c, input int width);
    logic [31:0] diff;
    diff = (now_c - last_c) & ((width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1));
    return diff >= 32'd2;
  endfunction

endpackage

// File: rtl/cfg_write_gate.sv
module cfg_write_gate #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          page_hi,
  input  logic          data_msb,
  input  logic [CW-1:0] cycle_now,
  output logic          accept
);
  import cfg_loader_pkg::*;

  logic          hit;
  logic          seen;
  logic [CW-1:0] last_cyc;
  logic          spaced;

  assign hit    = wr_en & page_hi;
  assign spaced = gap_ok(32'(cycle_now), 32'(last_cyc), CW);
  assign accept = hit & (data_msb | ~seen | spaced);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      last_cyc <= '0;
    end else if (hit) begin
      seen     <= 1'b1;
      last_cyc <= cycle_now;
    end
  end

  // R6: a plain write one cycle after another in-window write is dropped
  assert_adjacent_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && !data_msb && seen && $past(hit) && (cycle_now == CW'($past(cycle_now) + 1'b1)))
      |-> !accept)
    else $error("adjacent write accepted");

  // R3: a restart write is never filtered
  assert_restart_passes_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && data_msb) |-> accept)
    else $error("restart write filtered");

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
  parameter int SR_W = cfg_loader_pkg::SR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            data_msb,
  input  logic            data_lsb,
  output logic            commit,
  output logic            restart,
  output logic [SR_W-1:0] commit_val
);
  import cfg_loader_pkg::*;

  localparam int CNT_W = $clog2(SR_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SR_W - 1);

  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic             bit_in;

  assign restart    = accept & data_msb;
  assign bit_in     = accept & ~data_msb;
  assign commit_val = shift_step(sr, data_lsb);
  assign commit     = bit_in & (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || restart || commit) begin
      sr  <= '0;
      cnt <= '0;
    end else if (bit_in) begin
      sr  <= commit_val;
      cnt <= cnt + 1'b1;
    end
  end

  // R3: staging state empty after a restart
  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && sr == '0))
    else $error("restart left staging state");

  // R2: counter empty after a commit and never beyond the last index
  assert_commit_clears_R2: assert property (@(posedge clk) disable iff (rst)
    commit |=> cnt == '0)
    else $error("commit left counter set");

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_IDX)
    else $error("counter overflow");

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
  parameter int SR_W = cfg_loader_pkg::SR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic            restart,
  input  logic [1:0]      sel,
  input  logic [SR_W-1:0] val,
  output logic [SR_W-1:0] ctrl_q,
  output logic [SR_W-1:0] chr_lo_q,
  output logic [SR_W-1:0] chr_hi_q,
  output logic [SR_W-1:0] prg_q,
  output logic            last_hi_q
);
  import cfg_loader_pkg::*;

  localparam logic [SR_W-1:0] CTRL_INIT = SR_W'(5'b01100);
  localparam logic [SR_W-1:0] MODE_BITS = SR_W'(5'b01100);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_INIT;
      chr_lo_q  <= '0;
      chr_hi_q  <= '0;
      prg_q     <= '0;
      last_hi_q <= 1'b0;
    end else if (restart) begin
      ctrl_q <= ctrl_q | MODE_BITS;
    end else if (commit) begin
      case (reg_sel_e'(sel))
        SEL_CTRL:   ctrl_q <= val;
        SEL_CHR_LO: begin chr_lo_q <= val; last_hi_q <= 1'b0; end
        SEL_CHR_HI: begin chr_hi_q <= val; last_hi_q <= 1'b1; end
        default:    prg_q <= val;
      endcase
    end
  end

  // R3: restart forces both mode bits high and keeps the others
  assert_restart_mode_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ctrl_q[3:2] == 2'b11 && ctrl_q[4] == $past(ctrl_q[4])
                 && ctrl_q[1:0] == $past(ctrl_q[1:0])))
    else $error("restart mode bits wrong");

  // R2: registers hold when nothing is committed
  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!commit && !restart) |=> ($stable(ctrl_q) && $stable(chr_lo_q)
                               && $stable(chr_hi_q) && $stable(prg_q) && $stable(last_hi_q)))
    else $error("register changed without commit");

  // R8: a CHR-high commit sets the indicator
  assert_last_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == 2'd2) |=> last_hi_q)
    else $error("indicator not set");

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_page,
  input  logic [7:0]    wr_data,
  input  logic [CW-1:0] cycle_now,
  output logic [1:0]    mirror_mode,
  output logic          prg_slot_sel,
  output logic          prg_mode,
  output logic          chr_mode,
  output logic [4:0]    chr_bank_lo,
  output logic [4:0]    chr_bank_hi,
  output logic [3:0]    prg_bank,
  output logic          wram_off,
  output logic          last_chr_hi
);
  import cfg_loader_pkg::*;

  logic            accept;
  logic            commit;
  logic            restart;
  logic [SR_W-1:0] commit_val;
  logic [SR_W-1:0] ctrl_q, chr_lo_q, chr_hi_q, prg_q;
  logic            unused_data_mid;

  assign unused_data_mid = ^wr_data[6:1];

  cfg_write_gate #(.CW(CW)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .page_hi   (wr_page[2]),
    .data_msb  (wr_data[7]),
    .cycle_now (cycle_now),
    .accept    (accept)
  );

  cfg_bit_shifter #(.SR_W(SR_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .data_msb   (wr_data[7]),
    .data_lsb   (wr_data[0]),
    .commit     (commit),
    .restart    (restart),
    .commit_val (commit_val)
  );

  cfg_reg_file #(.SR_W(SR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .restart   (restart),
    .sel       (wr_page[1:0]),
    .val       (commit_val),
    .ctrl_q    (ctrl_q),
    .chr_lo_q  (chr_lo_q),
    .chr_hi_q  (chr_hi_q),
    .prg_q     (prg_q),
    .last_hi_q (last_chr_hi)
  );

  assign mirror_mode  = ctrl_q[1:0];
  assign prg_slot_sel = ctrl_q[2];
  assign prg_mode     = ctrl_q[3];
  assign chr_mode     = ctrl_q[4];
  assign chr_bank_lo  = chr_lo_q;
  assign chr_bank_hi  = chr_hi_q;
  assign prg_bank     = prg_q[3:0];
  assign wram_off     = prg_q[4];

  // R9: strobes outside the window never commit or restart
  assert_window_only_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_page[2] |-> (!commit && !restart))
    else $error("out-of-window strobe acted");

endmodule

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_page;
  logic [7:0]  wr_data;
  logic [15:0] cyc;
  logic [1:0]  mirror_mode;
  logic        prg_slot_sel, prg_mode, chr_mode, wram_off, last_chr_hi;
  logic [4:0]  chr_bank_lo, chr_bank_hi;
  logic [3:0]  prg_bank;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_ctrl, m_lo, m_hi, m_prg;
  logic       m_last;

  // {sel[1:0], value[4:0]}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 5'b10010}, {2'd1, 5'h1F}, {2'd2, 5'h0A}, {2'd3, 5'h1E},
    {2'd0, 5'b00111}, {2'd3, 5'h05}, {2'd2, 5'h11}, {2'd1, 5'h00}
  };

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 1'b1;
  end

  serial_cfg_loader #(.CW(16)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_page(wr_page), .wr_data(wr_data),
    .cycle_now(cyc), .mirror_mode(mirror_mode), .prg_slot_sel(prg_slot_sel),
    .prg_mode(prg_mode), .chr_mode(chr_mode), .chr_bank_lo(chr_bank_lo),
    .chr_bank_hi(chr_bank_hi), .prg_bank(prg_bank), .wram_off(wram_off),
    .last_chr_hi(last_chr_hi)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] page, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_page = page; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wr(input logic [2:0] page, input logic [7:0] d);
    strobe(page, d);
    idle();
  endtask

  // five spaced writes, LSB first, noise in data bits 6:1 (R1)
  task automatic load5(input logic [1:0] sel, input logic [4:0] v);
    for (int i = 0; i < 5; i++) wr({1'b1, sel}, {1'b0, 6'h2A ^ 6'(i), v[i]});
  endtask

  function automatic logic [20:0] observed();
    return {last_chr_hi, wram_off, prg_bank, chr_bank_hi, chr_bank_lo,
            chr_mode, prg_mode, prg_slot_sel, mirror_mode};
  endfunction

  function automatic logic [20:0] modeled();
    return {m_last, m_prg, m_hi, m_lo, m_ctrl};
  endfunction

  task automatic model_commit(input logic [1:0] sel, input logic [4:0] v);
    case (sel)
      2'd0: m_ctrl = v;
      2'd1: begin m_lo = v; m_last = 1'b0; end
      2'd2: begin m_hi = v; m_last = 1'b1; end
      default: m_prg = v;
    endcase
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hang expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_page = 3'b100; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_ctrl = 5'b01100; m_lo = '0; m_hi = '0; m_prg = '0; m_last = 1'b0;
    // R7 reset state (control 01100, all else zero), R8 indicator low
    check(32'(observed()), 32'(modeled()), "R7 reset state");
    check(32'(last_chr_hi), 32'd0, "R8 reset indicator");

    // table walk: R1 bit order, R2 selection, R4/R5 field mapping, R8 indicator
    foreach (VEC[k]) begin
      load5(VEC[k][6:5], VEC[k][4:0]);
      model_commit(VEC[k][6:5], VEC[k][4:0]);
      check(32'(observed()), 32'(modeled()),
            (VEC[k][6:5] == 2'd0) ? "R4 control fields via R1/R2" :
            (VEC[k][6:5] == 2'd3) ? "R5 PRG fields via R1/R2" : "R5 CHR bank and R8 via R2");
    end

    // R2: four bits must not commit
    for (int i = 0; i < 4; i++) wr(3'b101, 8'h01);
    check(32'(chr_bank_lo), 32'(m_lo), "R2 no commit after four bits");
    wr(3'b101, 8'h01);
    model_commit(2'd1, 5'h1F);
    check(32'(chr_bank_lo), 32'h1F, "R2 commit on fifth bit");

    // R3: control 10001 then restart -> 11101
    load5(2'd0, 5'b10001);
    model_commit(2'd0, 5'b10001);
    wr(3'b100, 8'h80);
    check(32'({chr_mode, prg_mode, prg_slot_sel, mirror_mode}), 32'b11101, "R3 restart sets mode bits");

    // R3 + R6: restart on an adjacent cycle still clears partial bits
    wr(3'b110, 8'h01);
    wr(3'b110, 8'h01);
    strobe(3'b110, 8'h01);
    strobe(3'b110, 8'h80);
    idle();
    m_ctrl = m_ctrl | 5'b01100;
    load5(2'd2, 5'b00110);
    model_commit(2'd2, 5'b00110);
    check(32'(chr_bank_hi), 32'd6, "R3 restart clears staging");
    check(32'(observed()), 32'(modeled()), "R3 other registers intact");

    // R6: three adjacent writes pass only the first, dropped write refreshes the timestamp
    strobe(3'b101, 8'h01);
    strobe(3'b101, 8'h00);
    strobe(3'b101, 8'h00);
    idle();
    wr(3'b101, 8'h00); wr(3'b101, 8'h01); wr(3'b101, 8'h00); wr(3'b101, 8'h01);
    model_commit(2'd1, 5'b10101);
    check(32'(chr_bank_lo), 32'd21, "R6 adjacent chain filtered");
    check(32'(last_chr_hi), 32'd0, "R8 indicator back low");

    // R6: adjacent pair commits one bit only
    strobe(3'b111, 8'h00);
    strobe(3'b111, 8'h01);
    idle();
    for (int i = 0; i < 4; i++) wr(3'b111, 8'h01);
    model_commit(2'd3, 5'b11110);
    check(32'({wram_off, prg_bank}), 32'b11110, "R6 pair commits one bit");

    // R9: out-of-window strobe neither shifts nor refreshes timestamp
    strobe(3'b111, 8'h01);
    strobe(3'b011, 8'h00);
    strobe(3'b111, 8'h00);
    idle();
    wr(3'b111, 8'h01); wr(3'b111, 8'h01);
    check(32'({wram_off, prg_bank}), 32'(m_prg), "R9 no early commit");
    wr(3'b111, 8'h00);
    model_commit(2'd3, 5'b01101);
    check(32'(prg_bank), 32'd13, "R9 out-of-window ignored, R5 bank");
    check(32'(wram_off), 32'd0, "R5 wram flag clear");

    // R7: reset mid-load
    wr(3'b100, 8'h01); wr(3'b100, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    m_ctrl = 5'b01100; m_lo = '0; m_hi = '0; m_prg = '0; m_last = 1'b0;
    check(32'(observed()), 32'(modeled()), "R7 reset returns defaults");
    load5(2'd2, 5'b01011);
    check(32'(chr_bank_hi), 32'd11, "R7 staging empty after reset");
    check(32'(last_chr_hi), 32'd1, "R8 indicator set");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule